// File: doc/BRIEF.md
# T1 Controlled-Slip Elastic Buffer

This block is a two-frame elastic store placed between a 24-channel DS1 byte stream and a 32-timeslot system bus frame. The writer presents one channel byte per write strobe. The reader pulls one byte per read strobe. Read timeslots past the last DS1 channel return an idle pattern. Both sides run on a single core clock, and each side is qualified by its own enable strobe and frame-start flag.

The read side is a two-state machine. In `RS_CHAN` it reads channel slots. The transition `chan_done` leads to `RS_FILL`, where it emits idle timeslots. The transition `frame_end` returns it to `RS_CHAN` and closes the read frame. A read strobe that carries the frame-start flag takes the `resync` transition, which enters `RS_CHAN` at slot 0 from either state. The slip decision is made only at `frame_end`. At that point the block measures how far the write pointer has run past the start of the next read frame. If the margin is too small, the reader re-reads its current half, so one frame is repeated. If the margin is too large, the reader stays on its current half, so the older frame is dropped. Each slip updates a toggle flag, a sticky flag, a maskable interrupt flag and a direction flag. Every second frame end the block captures the write-to-read phase.

A set-delay write moves the write pointer to a chosen distance ahead of the reader. This re-centres the store at a delay of less than one frame.

Top module: `t1_slip_buffer`

## Requirements
- R1: A read strobe in slots 0 to 23 returns, on `rd_data` in the following cycle, the byte stored at position `frame*24 + slot` of the current read half. After reset, each read frame returns the DS1 frame written one frame earlier.
- R2: A read strobe in slots 24 to 31 returns 0xFF in the following cycle and leaves the stored data untouched.
- R3: At the read strobe of slot 31, the separation `sep = (write position - start of the next read half) mod 48` is evaluated, where positions count `half*24 + channel`. If `sep < 2` the read half is kept and the slip is a repeat (`slip_dir` = 1). If `sep > 46` the read half is kept and the slip is a delete (`slip_dir` = 0). Otherwise the read half flips and no slip occurs. No slip happens at any other strobe.
- R4: Each slip inverts `slip_tgl` and sets `slip_lat`. A `lat_clr` pulse clears `slip_lat`. When a slip and `lat_clr` fall in the same cycle, `slip_lat` stays set.
- R5: A slip sets `slip_irq` only while `slip_mask` is 0. `irq_clr` clears it. A masked slip still sets `slip_lat`.
- R6: At the 2nd, 4th, 6th and later frame ends after reset, `ph_msb` takes `sep >= 24`, `ph_ts` takes `sep mod 24`, and `ph_bit` takes the fine offset of the last set-delay value.
- R7: A `sd_wr` pulse with value `{ts[7:3], fine[2:0]}` places the write pointer `min(ts,23)` slots past the read position. While the reader is in idle slots, the read position counts as the start of the next read half. The pulse also clears `ph_msb` in the next cycle.
- R8: After reset the reader is at half 1, slot 0, and the writer is at position 0. The store holds 0x00, `rd_data` is 0xFF, and all slip and phase outputs are 0.
- R9: Starting from the reset alignment (separation 24), a drift of the writer of up to 22 channel slots in either direction within one frame is absorbed without a slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low reset |
| wr_en | input | 1 | DS1 byte write strobe |
| wr_fs | input | 1 | with `wr_en`: byte is channel 0 |
| wr_data | input | 8 | DS1 channel byte |
| rd_en | input | 1 | system timeslot read strobe |
| rd_fs | input | 1 | with `rd_en`: strobe is timeslot 0 |
| rd_data | output | 8 | byte read, valid the cycle after `rd_en` |
| sd_wr | input | 1 | set-delay write pulse |
| sd_val | input | 8 | set-delay value, timeslot in [7:3], fine in [2:0] |
| slip_mask | input | 1 | 1 masks the slip interrupt |
| lat_clr | input | 1 | clears the sticky slip flag |
| irq_clr | input | 1 | clears the slip interrupt |
| slip_tgl | output | 1 | inverts on every slip |
| slip_dir | output | 1 | 1 repeat, 0 delete (last slip) |
| slip_lat | output | 1 | sticky slip flag |
| slip_irq | output | 1 | slip interrupt |
| ph_msb | output | 1 | phase: separation of a frame or more |
| ph_ts | output | 5 | phase: separation in slots mod 24 |
| ph_bit | output | 3 | phase: fine offset |

## Verification
The `frame_end` transition can slip in the same cycle as a `lat_clr` pulse. The bench forces this by raising `lat_clr` together with the slot-31 read strobe of a frame in which no bytes were written, which guarantees a repeat slip. The bench then requires `slip_lat` to read 1 afterwards. A sweep of writer drift from -24 to +23 slots at a single frame end checks the slip/no-slip boundaries, the direction, the masking and the captured phase against the separation formula.

// File: rtl/es_pkg.sv
package es_pkg;

    typedef enum logic [0:0] {
        RS_CHAN = 1'b0,
        RS_FILL = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic frame_end;
        logic slip;
        logic repeat_f;
    } slip_evt_t;

endpackage

// File: rtl/es_wr_ctrl.sv
module es_wr_ctrl #(
    parameter int CH     = 24,
    parameter int SD_TSW = 5,
    parameter int POS_W  = $clog2(2 * CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_fs,
    input  logic              sd_wr,
    input  logic [SD_TSW-1:0] sd_slots,
    input  logic [POS_W-1:0]  rd_pos,
    output logic [POS_W-1:0]  wr_pos,
    output logic              mem_we,
    output logic [POS_W-1:0]  mem_addr
);

    localparam int          DEPTH  = 2 * CH;
    localparam logic [POS_W:0] DEPTH_X = (POS_W + 1)'(DEPTH);
    localparam logic [POS_W-1:0] CH_P  = POS_W'(CH);
    localparam logic [SD_TSW-1:0] MAX_SD = SD_TSW'(CH - 1);

    logic [POS_W-1:0]  pos_q, pos_n;
    logic [POS_W-1:0]  addr;
    logic [SD_TSW-1:0] slots_lim;
    logic [POS_W:0]    sum;

    // Frame-start flag on a write moves the byte to channel 0 of the next half
    // unless the writer is already on a channel 0.
    always_comb begin
        if (wr_fs && (pos_q != '0) && (pos_q != CH_P))
            addr = (pos_q < CH_P) ? CH_P : '0;
        else
            addr = pos_q;
    end

    always_comb begin
        slots_lim = (sd_slots > MAX_SD) ? MAX_SD : sd_slots;
        sum       = (POS_W + 1)'(rd_pos) + (POS_W + 1)'(slots_lim);
        if (sum >= DEPTH_X)
            sum = sum - DEPTH_X;
    end

    always_comb begin
        pos_n  = pos_q;
        mem_we = 1'b0;
        if (sd_wr) begin
            pos_n = sum[POS_W-1:0];
        end else if (wr_en) begin
            mem_we = 1'b1;
            pos_n  = (addr == POS_W'(DEPTH - 1)) ? '0 : addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos_q <= '0;
        else
            pos_q <= pos_n;
    end

    assign wr_pos   = pos_q;
    assign mem_addr = addr;

endmodule

// File: rtl/es_rd_fsm.sv
module es_rd_fsm
    import es_pkg::*;
#(
    parameter int CH    = 24,
    parameter int TS    = 32,
    parameter int LO_TH = 2,
    parameter int HI_TH = 46,
    parameter int POS_W = $clog2(2 * CH),
    parameter int TSW   = $clog2(TS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rd_fs,
    input  logic [POS_W-1:0] wr_pos,
    output logic             rd_live,
    output logic [POS_W-1:0] rd_addr,
    output logic [POS_W-1:0] rd_pos,
    output logic [POS_W-1:0] sep,
    output slip_evt_t        evt
);

    localparam logic [POS_W:0]   DEPTH_X = (POS_W + 1)'(2 * CH);
    localparam logic [POS_W-1:0] CH_P    = POS_W'(CH);
    localparam logic [TSW-1:0]   LAST_CH = TSW'(CH - 1);
    localparam logic [TSW-1:0]   LAST_TS = TSW'(TS - 1);
    localparam logic [POS_W-1:0] LO_P    = POS_W'(LO_TH);
    localparam logic [POS_W-1:0] HI_P    = POS_W'(HI_TH);

    rd_state_e      state_q, state_n;
    logic [TSW-1:0] ts_q, ts_n, ts_cur;
    logic           half_q, half_n;
    logic [POS_W-1:0] next_start;
    logic [POS_W:0]   diff;

    // Separation of the writer from the start of the next read half.
    always_comb begin
        next_start = half_q ? '0 : CH_P;
        diff = (POS_W + 1)'(wr_pos) + DEPTH_X - (POS_W + 1)'(next_start);
        if (diff >= DEPTH_X)
            diff = diff - DEPTH_X;
        sep = diff[POS_W-1:0];
    end

    // Next-state and pointer logic.
    always_comb begin
        state_n       = state_q;
        ts_n          = ts_q;
        half_n        = half_q;
        ts_cur        = (rd_en && rd_fs) ? '0 : ts_q;
        evt           = '0;
        if (rd_en) begin
            if (rd_fs) begin
                state_n = RS_CHAN;                  // resync
                ts_n    = TSW'(1);
            end else begin
                unique case (state_q)
                    RS_CHAN: begin
                        ts_n = ts_q + 1'b1;
                        if (ts_q == LAST_CH)
                            state_n = RS_FILL;      // chan_done
                    end
                    RS_FILL: begin
                        if (ts_q == LAST_TS) begin  // frame_end
                            state_n       = RS_CHAN;
                            ts_n          = '0;
                            evt.frame_end = 1'b1;
                            evt.slip      = (sep < LO_P) || (sep > HI_P);
                            evt.repeat_f  = (sep < LO_P);
                            half_n        = evt.slip ? half_q : ~half_q;
                        end else begin
                            ts_n = ts_q + 1'b1;
                        end
                    end
                    default: state_n = RS_CHAN;
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_CHAN;
            ts_q    <= '0;
            half_q  <= 1'b1;
        end else begin
            state_q <= state_n;
            ts_q    <= ts_n;
            half_q  <= half_n;
        end
    end

    // Outputs toward storage and the write side.
    always_comb begin
        rd_live = 1'b0;
        rd_pos  = next_start;
        unique case (state_q)
            RS_CHAN: begin
                rd_live = 1'b1;
                rd_pos  = (half_q ? CH_P : '0) + POS_W'(ts_q);
            end
            RS_FILL: begin
                rd_live = rd_en && rd_fs;
                rd_pos  = next_start;
            end
            default: rd_live = 1'b0;
        endcase
        rd_addr = (half_q ? CH_P : '0) + POS_W'(ts_cur);
    end

endmodule

// File: rtl/es_slip_status.sv
module es_slip_status
    import es_pkg::*;
#(
    parameter int CH    = 24,
    parameter int POS_W = $clog2(2 * CH),
    parameter int TSW   = 5,
    parameter int FW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  slip_evt_t        evt,
    input  logic [POS_W-1:0] sep,
    input  logic             sd_wr,
    input  logic [FW-1:0]    sd_fine,
    input  logic             slip_mask,
    input  logic             lat_clr,
    input  logic             irq_clr,
    output logic             slip_tgl,
    output logic             slip_dir,
    output logic             slip_lat,
    output logic             slip_irq,
    output logic             ph_msb,
    output logic [TSW-1:0]   ph_ts,
    output logic [FW-1:0]    ph_bit
);

    localparam logic [POS_W-1:0] CH_P = POS_W'(CH);

    logic          pair_q;
    logic [FW-1:0] fine_q;
    logic          sample;
    logic [POS_W-1:0] sep_mod;

    assign sample  = evt.frame_end && pair_q;
    assign sep_mod = (sep >= CH_P) ? sep - CH_P : sep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slip_tgl <= 1'b0;
            slip_dir <= 1'b0;
            slip_lat <= 1'b0;
            slip_irq <= 1'b0;
            pair_q   <= 1'b0;
            fine_q   <= '0;
            ph_msb   <= 1'b0;
            ph_ts    <= '0;
            ph_bit   <= '0;
        end else begin
            if (evt.slip) begin
                slip_tgl <= ~slip_tgl;
                slip_dir <= evt.repeat_f;
            end
            if (evt.slip)
                slip_lat <= 1'b1;
            else if (lat_clr)
                slip_lat <= 1'b0;
            if (evt.slip && !slip_mask)
                slip_irq <= 1'b1;
            else if (irq_clr)
                slip_irq <= 1'b0;
            if (evt.frame_end)
                pair_q <= ~pair_q;
            if (sample) begin
                ph_ts  <= TSW'(sep_mod);
                ph_bit <= fine_q;
            end
            if (sd_wr) begin
                fine_q <= sd_fine;
                ph_msb <= 1'b0;
            end else if (sample) begin
                ph_msb <= (sep >= CH_P);
            end
        end
    end

endmodule

// File: rtl/t1_slip_buffer.sv
module t1_slip_buffer
    import es_pkg::*;
#(
    parameter int          CH    = 24,
    parameter int          TS    = 32,
    parameter int          DW    = 8,
    parameter int          LO_TH = 2,
    parameter int          HI_TH = 46,
    parameter logic [7:0]  IDLE  = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_fs,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          rd_fs,
    output logic [DW-1:0] rd_data,
    input  logic          sd_wr,
    input  logic [7:0]    sd_val,
    input  logic          slip_mask,
    input  logic          lat_clr,
    input  logic          irq_clr,
    output logic          slip_tgl,
    output logic          slip_dir,
    output logic          slip_lat,
    output logic          slip_irq,
    output logic          ph_msb,
    output logic [4:0]    ph_ts,
    output logic [2:0]    ph_bit
);

    localparam int DEPTH = 2 * CH;
    localparam int POS_W = $clog2(DEPTH);
    localparam int TSW   = $clog2(TS);

    logic [DW-1:0]    mem [DEPTH];
    logic             mem_we;
    logic [POS_W-1:0] mem_addr;
    logic [POS_W-1:0] wr_pos;
    logic [POS_W-1:0] rd_pos;
    logic [POS_W-1:0] rd_addr;
    logic [POS_W-1:0] sep;
    logic             rd_live;
    slip_evt_t        evt;

    es_wr_ctrl #(.CH(CH), .SD_TSW(5), .POS_W(POS_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_fs    (wr_fs),
        .sd_wr    (sd_wr),
        .sd_slots (sd_val[7:3]),
        .rd_pos   (rd_pos),
        .wr_pos   (wr_pos),
        .mem_we   (mem_we),
        .mem_addr (mem_addr)
    );

    es_rd_fsm #(.CH(CH), .TS(TS), .LO_TH(LO_TH), .HI_TH(HI_TH),
                .POS_W(POS_W), .TSW(TSW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_fs   (rd_fs),
        .wr_pos  (wr_pos),
        .rd_live (rd_live),
        .rd_addr (rd_addr),
        .rd_pos  (rd_pos),
        .sep     (sep),
        .evt     (evt)
    );

    es_slip_status #(.CH(CH), .POS_W(POS_W), .TSW(5), .FW(3)) u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .sep       (sep),
        .sd_wr     (sd_wr),
        .sd_fine   (sd_val[2:0]),
        .slip_mask (slip_mask),
        .lat_clr   (lat_clr),
        .irq_clr   (irq_clr),
        .slip_tgl  (slip_tgl),
        .slip_dir  (slip_dir),
        .slip_lat  (slip_lat),
        .slip_irq  (slip_irq),
        .ph_msb    (ph_msb),
        .ph_ts     (ph_ts),
        .ph_bit    (ph_bit)
    );

    // Two-frame store.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (mem_we) begin
            mem[mem_addr] <= wr_data;
        end
    end

    // Registered read port.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= DW'(IDLE);
        else if (rd_en)
            rd_data <= rd_live ? mem[rd_addr] : DW'(IDLE);
    end

endmodule

// File: rtl/es_slip_chk.sv
module es_slip_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          rd_live,
    input logic [DW-1:0] rd_data,
    input logic          sd_wr,
    input logic          slip_mask,
    input logic          slip_tgl,
    input logic          slip_dir,
    input logic          slip_lat,
    input logic          slip_irq,
    input logic          ph_msb
);

    // R2: idle timeslots read back the idle pattern
    a_r2_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_live) |=> (rd_data == {DW{1'b1}}));

    // R3: slips only follow a read strobe
    a_r3_slip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slip_tgl) |-> $past(rd_en));

    // R3: direction changes only with a slip
    a_r3_dir_with_slip: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slip_dir) |-> !$stable(slip_tgl));

    // R4: every slip leaves the sticky flag set
    a_r4_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slip_tgl) |-> slip_lat);

    // R5: interrupt rises only while unmasked
    a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slip_irq) |-> !$past(slip_mask));

    // R7: set-delay write clears the frame-count MSB
    a_r7_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sd_wr |=> !ph_msb);

endmodule

bind t1_slip_buffer es_slip_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_live   (rd_live),
    .rd_data   (rd_data),
    .sd_wr     (sd_wr),
    .slip_mask (slip_mask),
    .slip_tgl  (slip_tgl),
    .slip_dir  (slip_dir),
    .slip_lat  (slip_lat),
    .slip_irq  (slip_irq),
    .ph_msb    (ph_msb)
);

// File: tb/t1_slip_buffer_bench.sv
module t1_slip_buffer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_fs = 1'b0, rd_en = 1'b0, rd_fs = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sd_wr = 1'b0;
    logic [7:0] sd_val = '0;
    logic       slip_mask = 1'b0, lat_clr = 1'b0, irq_clr = 1'b0;
    logic       slip_tgl, slip_dir, slip_lat, slip_irq, ph_msb;
    logic [4:0] ph_ts;
    logic [2:0] ph_bit;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int wr_g  = 0;

    always #10 clk = ~clk;

    t1_slip_buffer u_t1_slip_buffer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fs(wr_fs), .wr_data(wr_data),
        .rd_en(rd_en), .rd_fs(rd_fs), .rd_data(rd_data), .sd_wr(sd_wr),
        .sd_val(sd_val), .slip_mask(slip_mask), .lat_clr(lat_clr),
        .irq_clr(irq_clr), .slip_tgl(slip_tgl), .slip_dir(slip_dir),
        .slip_lat(slip_lat), .slip_irq(slip_irq), .ph_msb(ph_msb),
        .ph_ts(ph_ts), .ph_bit(ph_bit)
    );

    function automatic logic [7:0] pat(input int g);
        return 8'((g * 7 + 3) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wr_g = 0;
        @(negedge clk);
    endtask

    // nw writes, then one 32-slot read frame; rfid<-1 skips data checks,
    // rfid==-1 expects reset content, otherwise DS1 frame rfid.
    task automatic run_iter(input int nw, input int rfid, input bit clr_end);
        for (int k = 0; k < nw; k++) begin
            wr_en = 1'b1; wr_data = pat(wr_g); wr_g++;
            @(negedge clk);
            wr_en = 1'b0;
        end
        for (int ts = 0; ts < 32; ts++) begin
            rd_en = 1'b1;
            lat_clr = (ts == 31) && clr_end;
            @(negedge clk);
            rd_en = 1'b0; lat_clr = 1'b0;
            if (ts >= 24)
                chk("R2 idle slot", rd_data, 8'hFF);
            else if (rfid == -1)
                chk("R8 reset store", rd_data, 0);
            else if (rfid >= 0)
                chk("R1 read data", rd_data, pat(rfid * 24 + ts));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 rd_data", rd_data, 8'hFF);
        chk("R8 slip_tgl", slip_tgl, 0);
        chk("R8 slip_lat", slip_lat, 0);
        chk("R8 slip_irq", slip_irq, 0);
        chk("R8 ph_msb", ph_msb, 0);
        chk("R8 ph_ts", ph_ts, 0);

        // R1/R2: steady transfer, read frame j returns DS1 frame j-1
        for (int j = 0; j < 5; j++)
            run_iter(24, j - 1, 1'b0);
        chk("R9 no slip steady", slip_tgl, 0);
        chk("R6 phase msb steady", ph_msb, 1);
        chk("R6 phase ts steady", ph_ts, 0);

        // R3/R5/R6/R9: sweep writer drift at the second frame end
        for (int d = -24; d <= 23; d++) begin
            int sep;
            bit sl, rp;
            do_reset();
            slip_mask = (d % 2) != 0;
            run_iter(24, -2, 1'b0);
            run_iter(24 + d, -2, 1'b0);
            sep = 24 + d;
            sl = (sep < 2) || (sep > 46);
            rp = sep < 2;
            chk("R3 slip", slip_tgl, int'(sl));
            chk("R3 dir", slip_dir, int'(sl && rp));
            chk("R4 latch", slip_lat, int'(sl));
            chk("R5 irq mask", slip_irq, int'(sl && !slip_mask));
            chk("R6 ph_msb", ph_msb, int'(sep >= 24));
            chk("R6 ph_ts", ph_ts, sep % 24);
            chk("R6 ph_bit", ph_bit, 0);
            slip_mask = 1'b0;
        end

        // R3: repeat slip re-reads the same half
        do_reset();
        run_iter(24, -1, 1'b0);
        run_iter(0, 0, 1'b0);
        chk("R3 repeat slip", slip_tgl, 1);
        run_iter(24, 0, 1'b0);
        run_iter(24, 1, 1'b0);
        chk("R3 no further slip", slip_tgl, 1);

        // R4: slip and latch clear in the same cycle; set wins
        do_reset();
        run_iter(24, -1, 1'b0);
        run_iter(0, -2, 1'b1);
        chk("R4 set wins over clear", slip_lat, 1);
        lat_clr = 1'b1; irq_clr = 1'b1;
        @(negedge clk);
        lat_clr = 1'b0; irq_clr = 1'b0;
        chk("R4 latch cleared", slip_lat, 0);
        chk("R5 irq cleared", slip_irq, 0);

        // R7: set-delay 0xBC re-centres to 23 slots
        do_reset();
        run_iter(24, -2, 1'b0);
        run_iter(24, -2, 1'b0);
        chk("R7 msb before", ph_msb, 1);
        sd_val = 8'hBC; sd_wr = 1'b1;
        @(negedge clk);
        sd_wr = 1'b0;
        chk("R7 msb cleared", ph_msb, 0);
        run_iter(24, -2, 1'b0);
        run_iter(24, -2, 1'b0);
        chk("R7 no slip", slip_tgl, 0);
        chk("R7 phase ts", ph_ts, 23);
        chk("R7 phase msb", ph_msb, 0);
        chk("R7 phase fine", ph_bit, 4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule